// File: doc/BRIEF.md
# DAC Load Timing Advance Generator

This block produces the single-clock strobe that tells a DAC to take its next sample. It runs on a step clock that ticks 32 times per sample period. A free-running phase counter splits every sample period into 32 steps, and a frame-ready reference from the ADC side forces the counter back to step 0. With no advance programmed, the load strobe lands in the step just before the ADC frame-ready cycle.

A 5-bit advance value moves the strobe earlier in whole steps. Each step is 1/32 of a sample period, so the strobe can be pulled forward by 0 to 31/32 of a sample. In a chain that runs from the ADC to the DAC, this shortens the group delay.

The advance value is held in a staging register. The register accepts writes only while the DAC is powered down. A written value is moved into the active register when the counter wraps to step 0, so the timing never shifts partway through an interval.

Top module: `dac_load_adv`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `dac_load` is low. Reset sets both the staged and active advance values to 0 and the phase to step 0.
- R2: A cycle with `frame_ref` high is step 0, and the next cycle is step 1. With no `frame_ref`, the phase rises by one each clock and wraps from step 31 to step 0.
- R3: With advance 0, `dac_load` is high in step 31, the cycle directly before the `frame_ref` cycle.
- R4: With advance value a (0..31), `dac_load` is high in step 31−a, which is a+1 cycles before the next `frame_ref`. With a = 31 it coincides with the `frame_ref` cycle.
- R5: Every 32-step interval in lock contains exactly one `dac_load` cycle.
- R6: A write (`adv_we` high, value on `adv_val`) is ignored while `dac_pwr_up` is high. The advance in use stays as it was, also after power-down, until a new write is made.
- R7: An accepted write takes effect in the first interval that starts after the edge where the write is stored. A write in step 31 therefore applies one interval later. The interval in which a write happens keeps the old timing and still has exactly one pulse.
- R8: When `frame_ref` is missing, the counter free-runs and the strobe stays at the same step. An early `frame_ref` restarts the phase at step 0, and the strobe then follows the new phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock, 32 ticks per sample |
| rst | input | 1 | Synchronous active-high reset |
| frame_ref | input | 1 | ADC frame-ready reference; its cycle is step 0 |
| adv_we | input | 1 | Write strobe for the advance value |
| adv_val | input | 5 | Advance value, in steps |
| dac_pwr_up | input | 1 | DAC powered up; blocks advance writes while high |
| dac_load | output | 1 | Registered one-step DAC load strobe |

## Verification
The hardest case to reach is a change of advance while an interval is in progress. A pulse could be skipped or doubled if the new value moved the target step across the current phase. The stimulus writes a larger and then a smaller advance partway through an interval, on both sides of the current target, and counts the pulses in that interval and in the next one. It also writes in step 31, the cycle of the wrap itself, and confirms that the value applies one interval later. Early and missing `frame_ref` intervals cover the resynchronisation path.

// File: rtl/dla_pkg.sv
package dla_pkg;
  localparam int DLA_PHASE_W = 5;
  localparam int DLA_LEAD    = 1;

  function automatic int dla_steps(input int phase_w);
    return 1 << phase_w;
  endfunction
endpackage

// File: rtl/dla_phase_ctr.sv
module dla_phase_ctr #(
  parameter int PHASE_W = dla_pkg::DLA_PHASE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_ref,
  output logic [PHASE_W-1:0] phase_now,
  output logic [PHASE_W-1:0] phase_next,
  output logic               wrap_next
);
  localparam logic [PHASE_W-1:0] PH_ZERO = '0;
  localparam logic [PHASE_W-1:0] PH_ONE  = PHASE_W'(1);
  localparam logic [PHASE_W-1:0] PH_MAX  = '1;

  logic [PHASE_W-1:0] phase_q;

  // frame_ref marks step 0 of the current cycle
  assign phase_now  = frame_ref ? PH_ZERO : phase_q;
  assign phase_next = phase_now + PH_ONE;
  assign wrap_next  = (phase_next == PH_ZERO);

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_ZERO;
    else     phase_q <= phase_next;
  end

  AST_REF_RESYNC: assert property (@(posedge clk) disable iff (rst)
    frame_ref |=> (phase_q == PH_ONE)); // R2
  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_MAX && !frame_ref) |=> (phase_q == PH_ZERO)); // R2
endmodule

// File: rtl/dla_adv_reg.sv
module dla_adv_reg #(
  parameter int PHASE_W = dla_pkg::DLA_PHASE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               adv_we,
  input  logic [PHASE_W-1:0] adv_val,
  input  logic               dac_pwr_up,
  input  logic               wrap_next,
  output logic [PHASE_W-1:0] adv_next
);
  logic [PHASE_W-1:0] stage_q;
  logic [PHASE_W-1:0] act_q;
  logic               wr_ok;

  assign wr_ok    = adv_we && !dac_pwr_up;
  // value that governs the cycle after this edge
  assign adv_next = wrap_next ? stage_q : act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      act_q   <= '0;
    end else begin
      if (wr_ok)     stage_q <= adv_val;
      if (wrap_next) act_q   <= stage_q;
    end
  end

  AST_FROZEN_PWR: assert property (@(posedge clk) disable iff (rst)
    dac_pwr_up |=> $stable(stage_q)); // R6
  AST_ACT_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    !wrap_next |=> $stable(act_q)); // R7
endmodule

// File: rtl/dla_strobe.sv
module dla_strobe #(
  parameter int PHASE_W = dla_pkg::DLA_PHASE_W,
  parameter int LEAD    = dla_pkg::DLA_LEAD
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] phase_next,
  input  logic [PHASE_W-1:0] adv_next,
  output logic               dac_load
);
  localparam logic [PHASE_W-1:0] LEAD_V  = PHASE_W'(LEAD);
  localparam logic [PHASE_W-1:0] PH_ZERO = '0;

  logic [PHASE_W-1:0] target;
  logic               hit;

  // default spot is LEAD steps before step 0, pulled earlier by the advance
  assign target = PH_ZERO - LEAD_V - adv_next;
  assign hit    = (phase_next == target);

  always_ff @(posedge clk) begin
    if (rst) dac_load <= 1'b0;
    else     dac_load <= hit;
  end
endmodule

// File: rtl/dac_load_adv.sv
module dac_load_adv #(
  parameter int PHASE_W = dla_pkg::DLA_PHASE_W,
  parameter int LEAD    = dla_pkg::DLA_LEAD
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_ref,
  input  logic               adv_we,
  input  logic [PHASE_W-1:0] adv_val,
  input  logic               dac_pwr_up,
  output logic               dac_load
);
  localparam logic [PHASE_W-1:0] PH_ZERO = '0;

  logic [PHASE_W-1:0] phase_now;
  logic [PHASE_W-1:0] phase_next;
  logic               wrap_next;
  logic [PHASE_W-1:0] adv_next;

  dla_phase_ctr #(.PHASE_W(PHASE_W)) u_phase (
    .clk(clk), .rst(rst), .frame_ref(frame_ref),
    .phase_now(phase_now), .phase_next(phase_next), .wrap_next(wrap_next)
  );

  dla_adv_reg #(.PHASE_W(PHASE_W)) u_adv (
    .clk(clk), .rst(rst), .adv_we(adv_we), .adv_val(adv_val),
    .dac_pwr_up(dac_pwr_up), .wrap_next(wrap_next), .adv_next(adv_next)
  );

  dla_strobe #(.PHASE_W(PHASE_W), .LEAD(LEAD)) u_strobe (
    .clk(clk), .rst(rst), .phase_next(phase_next),
    .adv_next(adv_next), .dac_load(dac_load)
  );

  // pulse bookkeeping per interval, used only by the checks below
  logic seen_q;
  always_ff @(posedge clk) begin
    if (rst)                     seen_q <= 1'b0;
    else if (phase_now == PH_ZERO) seen_q <= dac_load;
    else                         seen_q <= seen_q | dac_load;
  end

  AST_ONE_PER_IV: assert property (@(posedge clk) disable iff (rst)
    (phase_now != PH_ZERO && seen_q) |-> !dac_load); // R5
  AST_RST_QUIET: assert property (@(posedge clk)
    rst |=> !dac_load); // R1
endmodule

// File: tb/dac_load_adv_bench.sv
`timescale 1ns/1ps
module dac_load_adv_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_ref = 1'b0;
  logic       adv_we = 1'b0;
  logic [4:0] adv_val = '0;
  logic       dac_pwr_up = 1'b0;
  logic       dac_load;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dac_load_adv u_dac_load_adv (
    .clk(clk), .rst(rst), .frame_ref(frame_ref), .adv_we(adv_we),
    .adv_val(adv_val), .dac_pwr_up(dac_pwr_up), .dac_load(dac_load)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one interval of len steps; cycle i is step i when ref0 puts frame_ref at i==0
  task automatic run_iv(input int len, input bit ref0, input int wr_at,
                        input int wr_val, output int cnt, output int pos);
    cnt = 0; pos = -1;
    for (int i = 0; i < len; i++) begin
      frame_ref = ref0 && (i == 0);
      adv_we    = (i == wr_at);
      adv_val   = 5'(wr_val);
      if (dac_load) begin cnt++; pos = i; end
      @(posedge clk); #1;
    end
    frame_ref = 1'b0; adv_we = 1'b0;
  endtask

  task automatic t_reset();
    int c, p;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(dac_load == 1'b0, "R1 low in reset", dac_load, 0);
    rst = 1'b0;
    @(posedge clk); #1;
    check(dac_load == 1'b0, "R1 low after reset", dac_load, 0);
    run_iv(32, 1, -1, 0, c, p);
    run_iv(32, 1, -1, 0, c, p);
    check(p == 31, "R3 default position", p, 31);
    check(c == 1, "R5 count default", c, 1);
  endtask

  task automatic t_sweep();
    int c, p, prev;
    prev = 0;
    for (int a = 0; a < 32; a++) begin
      run_iv(32, 1, 5, a, c, p);
      check(c == 1 && p == 31 - prev, "R7 write interval keeps old", p, 31 - prev);
      run_iv(32, 1, -1, 0, c, p);
      check(p == 31 - a, "R4 advance position", p, 31 - a);
      check(c == 1, "R5 one pulse", c, 1);
      prev = a;
    end
  endtask

  task automatic t_pwr();
    int c, p;
    run_iv(32, 1, 3, 9, c, p);
    run_iv(32, 1, -1, 0, c, p);
    check(p == 22, "R4 set 9", p, 22);
    dac_pwr_up = 1'b1;
    run_iv(32, 1, 4, 20, c, p);
    check(p == 22, "R6 write while powered", p, 22);
    run_iv(32, 1, -1, 0, c, p);
    check(p == 22, "R6 ignored next interval", p, 22);
    dac_pwr_up = 1'b0;
    run_iv(32, 1, -1, 0, c, p);
    check(p == 22, "R6 still old after power-down", p, 22);
    run_iv(32, 1, 4, 20, c, p);
    run_iv(32, 1, -1, 0, c, p);
    check(p == 11, "R6 accepted when down", p, 11);
  endtask

  task automatic t_mid();
    int c, p;
    run_iv(32, 1, 0, 2, c, p);
    run_iv(32, 1, -1, 0, c, p);
    check(p == 29, "R4 set 2", p, 29);
    run_iv(32, 1, 10, 30, c, p);
    check(c == 1 && p == 29, "R7 raise mid interval", p, 29);
    run_iv(32, 1, -1, 0, c, p);
    check(c == 1 && p == 1, "R7 raise applied", p, 1);
    run_iv(32, 1, 20, 2, c, p);
    check(c == 1 && p == 1, "R7 lower mid interval", p, 1);
    run_iv(32, 1, -1, 0, c, p);
    check(c == 1 && p == 29, "R7 lower applied", p, 29);
    run_iv(32, 1, 31, 7, c, p);
    check(c == 1 && p == 29, "R7 write in step 31", p, 29);
    run_iv(32, 1, -1, 0, c, p);
    check(c == 1 && p == 29, "R7 step 31 write delayed", p, 29);
    run_iv(32, 1, -1, 0, c, p);
    check(c == 1 && p == 24, "R7 step 31 write applied", p, 24);
  endtask

  task automatic t_resync();
    int c, p;
    run_iv(32, 0, -1, 0, c, p);
    check(c == 1 && p == 24, "R8 missing ref free-run", p, 24);
    run_iv(32, 1, -1, 0, c, p);
    check(c == 1 && p == 24, "R2 ref aligned", p, 24);
    run_iv(12, 1, -1, 0, c, p);
    check(c == 0, "R8 short interval no pulse", c, 0);
    run_iv(32, 1, -1, 0, c, p);
    check(c == 1 && p == 24, "R8 early ref restarts phase", p, 24);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_pwr();
    t_mid();
    t_resync();
    done = 1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      summary();
    end
  end
endmodule